// File: doc/BRIEF.md
# Decode-Stage Branch Resolution Unit

This unit owns the fetch program counter of a five-stage in-order pipeline and settles every control-flow decision while the instruction sits in decode. Two kinds of conditional branch are supported: one that is taken when its source register holds zero, and one that is taken when it does not. The condition comes from a zero comparator on the source register value. The target comes from a dedicated adder that adds the sign-extended immediate to the branch's own address. An unconditional jump builds its address from the instruction's target field. Because the decision is made one stage after fetch, a taken transfer costs one fetch slot instead of three.

The lost slot is handled according to a build-time policy. With the delay-slot policy, the instruction fetched right after a branch or jump always runs, and control moves to the target after it. With the predict-not-taken policy, fetch continues sequentially. When the transfer is taken, the unit raises a kill flag for the decode-stage occupant on the following cycle. The surrounding pipeline treats that occupant as a no-op and lets it update no state. The unit also ignores a killed occupant itself.

A branch whose source register is about to be written by the instruction in execute waits one cycle. During that cycle the fetch address is held, and the branch is evaluated once the producer has moved on.

Top module: `brr_top`

## Requirements
- R1: While reset is active the fetch address equals the reset address (zero by default), the kill flag is low and no stall is signalled.
- R2: When decode holds no taken control-flow instruction and no stall applies, next_pc_o equals the fetch address plus 4, and the fetch address takes that value at the next rising clock edge.
- R3: The operation code is 2 bits wide: 0 means not a control-flow instruction, 1 means branch-if-zero, 2 means branch-if-nonzero and 3 means jump. Branch-if-zero is taken exactly when the source value is all zeros, and branch-if-nonzero is taken exactly when it is not. The target of a taken branch is the decode PC plus the sign-extended immediate.
- R4: A jump (code 3) is always taken. Its target is the upper bits of the decode PC above the field, followed by the target field, followed by two zero bits.
- R5: A taken transfer that is decided in decode appears on the fetch address at the next rising edge, so the penalty is a single fetch slot.
- R6: With the delay-slot policy the kill flag never rises, so the instruction after a taken branch or jump always executes.
- R7: With the predict-not-taken policy the kill flag is high for exactly the one cycle after a taken transfer and low after any other cycle.
- R8: While the kill flag is high, the decode occupant produces no redirect and no stall, whatever its operation code and operands.
- R9: A conditional branch whose nonzero source index equals the destination index of a register-writing instruction in execute raises stall_o and holds the fetch address for that cycle. Jumps never stall.
- R10: A source index of zero never causes a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| id_valid | input | 1 | Decode latch holds an instruction |
| id_op | input | 2 | Control-flow code of the decode instruction |
| id_pc | input | XLEN | Address of the decode instruction |
| id_rs_idx | input | RIDX_W | Source register index |
| id_rs_val | input | XLEN | Source register value |
| id_imm | input | IMM_W | Branch displacement, sign-extended inside |
| id_jfield | input | JT_W | Jump target field |
| ex_wr_en | input | 1 | Instruction in execute writes a register |
| ex_rd | input | RIDX_W | Destination index of the execute instruction |
| fetch_pc_o | output | XLEN | Current fetch address |
| next_pc_o | output | XLEN | Fetch address for the next cycle |
| id_kill_o | output | 1 | Decode occupant is squashed |
| stall_o | output | 1 | Hold fetch and decode this cycle |

## Verification
Two functions can meet in the same cycle in two ways. The first is a squash of the decode occupant while that occupant is itself a taken branch or a hazard-carrying branch. The second is a producer hazard in the cycle in which a branch would otherwise redirect. Directed cases set up back-to-back taken branches, a branch behind an execute-stage writer, and a jump and a register-zero branch behind such a writer. Seeded random traffic then draws register indices from a small set, so that matches and taken branches come often. Both policy builds are driven with the same stimulus. A bench model predicts the fetch address, the next address, the kill flag and the stall flag on every cycle, and the judgment is that the squash wins: a killed occupant neither redirects nor stalls.

// File: rtl/brr_pkg.sv
package brr_pkg;

   typedef enum logic [1:0] {
      BR_OP_NONE = 2'd0,
      BR_OP_BEQZ = 2'd1,
      BR_OP_BNEZ = 2'd2,
      BR_OP_JMP  = 2'd3
   } br_op_e;

   localparam int unsigned BRR_INSTR_BYTES = 4;

   typedef struct packed {
      logic is_cond;
      logic is_jump;
      logic take;
   } brr_dec_t;

endpackage

// File: rtl/brr_cond_eval.sv
module brr_cond_eval
   import brr_pkg::*;
#(
   parameter int unsigned XLEN = 32
) (
   input  logic            valid_i,
   input  br_op_e          op_i,
   input  logic [XLEN-1:0] rs_val_i,
   output brr_dec_t        dec_o
);

   logic rs_zero;

   assign rs_zero = (rs_val_i == '0);

   always_comb begin
      dec_o = '0;
      if (valid_i) begin
         case (op_i)
            BR_OP_BEQZ: begin
               dec_o.is_cond = 1'b1;
               dec_o.take    = rs_zero;
            end
            BR_OP_BNEZ: begin
               dec_o.is_cond = 1'b1;
               dec_o.take    = ~rs_zero;
            end
            BR_OP_JMP: begin
               dec_o.is_jump = 1'b1;
               dec_o.take    = 1'b1;
            end
            default: dec_o = '0;
         endcase
      end
   end

   always_comb begin
      if (valid_i) begin
         a_r3_flags_exclusive: assert (!(dec_o.is_cond && dec_o.is_jump));
      end
   end

endmodule

// File: rtl/brr_target_gen.sv
module brr_target_gen
   import brr_pkg::*;
#(
   parameter int unsigned XLEN  = 32,
   parameter int unsigned IMM_W = 16,
   parameter int unsigned JT_W  = 26
) (
   input  logic [XLEN-1:0]  cur_pc_i,
   input  logic [IMM_W-1:0] imm_i,
   input  logic [JT_W-1:0]  jfield_i,
   input  logic             is_jump_i,
   output logic [XLEN-1:0]  target_o
);

   localparam int unsigned ALIGN_W = $clog2(BRR_INSTR_BYTES);
   localparam int unsigned JLOW_W  = JT_W + ALIGN_W;

   logic [XLEN-1:0] imm_ext;
   logic [XLEN-1:0] br_target;
   logic [XLEN-1:0] jmp_target;

   generate
      if (IMM_W < XLEN) begin : g_sext
         assign imm_ext = {{(XLEN-IMM_W){imm_i[IMM_W-1]}}, imm_i};
      end else begin : g_full
         assign imm_ext = imm_i[XLEN-1:0];
      end
   endgenerate

   assign br_target = cur_pc_i + imm_ext;

   generate
      if (JLOW_W < XLEN) begin : g_jregion
         assign jmp_target = {cur_pc_i[XLEN-1:JLOW_W], jfield_i, {ALIGN_W{1'b0}}};
      end else begin : g_jfull
         assign jmp_target = {jfield_i, {ALIGN_W{1'b0}}};
      end
   endgenerate

   assign target_o = is_jump_i ? jmp_target : br_target;

endmodule

// File: rtl/brr_hazard.sv
module brr_hazard #(
   parameter int unsigned RIDX_W = 5
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              valid_i,
   input  logic              reads_rs_i,
   input  logic [RIDX_W-1:0] rs_idx_i,
   input  logic              ex_wr_en_i,
   input  logic [RIDX_W-1:0] ex_rd_i,
   output logic              stall_o
);

   logic idx_match;
   logic idx_live;

   assign idx_live  = (rs_idx_i != '0);
   assign idx_match = ex_wr_en_i && (ex_rd_i == rs_idx_i);
   assign stall_o   = valid_i && reads_rs_i && idx_live && idx_match;

   a_r10_zero_index_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rs_idx_i == '0) |-> !stall_o);

   a_r9_stall_needs_writer: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stall_o |-> ex_wr_en_i);

endmodule

// File: rtl/brr_top.sv
module brr_top
   import brr_pkg::*;
#(
   parameter int unsigned    XLEN       = 32,
   parameter int unsigned    IMM_W      = 16,
   parameter int unsigned    JT_W       = 26,
   parameter int unsigned    RIDX_W     = 5,
   parameter logic [XLEN-1:0] RESET_PC  = '0,
   parameter bit             DELAY_SLOT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              id_valid,
   input  logic [1:0]        id_op,
   input  logic [XLEN-1:0]   id_pc,
   input  logic [RIDX_W-1:0] id_rs_idx,
   input  logic [XLEN-1:0]   id_rs_val,
   input  logic [IMM_W-1:0]  id_imm,
   input  logic [JT_W-1:0]   id_jfield,
   input  logic              ex_wr_en,
   input  logic [RIDX_W-1:0] ex_rd,
   output logic [XLEN-1:0]   fetch_pc_o,
   output logic [XLEN-1:0]   next_pc_o,
   output logic              id_kill_o,
   output logic              stall_o
);

   localparam int unsigned   ALIGN_W = $clog2(BRR_INSTR_BYTES);
   localparam logic [XLEN-1:0] STEP  = XLEN'(BRR_INSTR_BYTES);

   generate
      if (IMM_W > XLEN) begin : g_bad_imm
         $error("brr_top: IMM_W exceeds XLEN");
      end
      if (JT_W + ALIGN_W > XLEN) begin : g_bad_jt
         $error("brr_top: jump field does not fit XLEN");
      end
      if (RIDX_W < 1) begin : g_bad_ridx
         $error("brr_top: RIDX_W must be positive");
      end
   endgenerate

   logic [XLEN-1:0] pc_q;
   logic [XLEN-1:0] seq_pc;
   logic [XLEN-1:0] tgt;
   logic [XLEN-1:0] next_pc;
   logic            kill_q;
   logic            eff_valid;
   logic            stall;
   logic            redirect;
   brr_dec_t        dec;

   assign eff_valid = id_valid & ~kill_q;

   brr_cond_eval #(.XLEN(XLEN)) u_cond (
      .valid_i  (eff_valid),
      .op_i     (br_op_e'(id_op)),
      .rs_val_i (id_rs_val),
      .dec_o    (dec)
   );

   brr_hazard #(.RIDX_W(RIDX_W)) u_haz (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .valid_i    (eff_valid),
      .reads_rs_i (dec.is_cond),
      .rs_idx_i   (id_rs_idx),
      .ex_wr_en_i (ex_wr_en),
      .ex_rd_i    (ex_rd),
      .stall_o    (stall)
   );

   brr_target_gen #(.XLEN(XLEN), .IMM_W(IMM_W), .JT_W(JT_W)) u_tgt (
      .cur_pc_i  (id_pc),
      .imm_i     (id_imm),
      .jfield_i  (id_jfield),
      .is_jump_i (dec.is_jump),
      .target_o  (tgt)
   );

   assign redirect = dec.take & ~stall;
   assign seq_pc   = pc_q + STEP;

   always_comb begin
      if (stall) begin
         next_pc = pc_q;
      end else if (redirect) begin
         next_pc = tgt;
      end else begin
         next_pc = seq_pc;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q <= RESET_PC;
      end else begin
         pc_q <= next_pc;
      end
   end

   generate
      if (DELAY_SLOT) begin : g_delay_slot
         assign kill_q = 1'b0;
      end else begin : g_squash
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               kill_q <= 1'b0;
            end else begin
               kill_q <= redirect;
            end
         end

         a_r7_kill_after_taken: assert property (@(posedge clk) disable iff (!rst_n)
            redirect |=> id_kill_o);

         a_r7_kill_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
            !redirect |=> !id_kill_o);
      end
   endgenerate

   assign fetch_pc_o = pc_q;
   assign next_pc_o  = next_pc;
   assign id_kill_o  = kill_q;
   assign stall_o    = stall;

   a_r5_target_lands: assert property (@(posedge clk) disable iff (!rst_n)
      redirect |=> (fetch_pc_o == $past(tgt)));

   a_r2_sequential_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!dec.take && !stall) |=> (fetch_pc_o == $past(fetch_pc_o) + STEP));

   a_r9_stall_holds_pc: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> $stable(fetch_pc_o));

   a_r8_killed_inert: assert property (@(posedge clk) disable iff (!rst_n)
      id_kill_o |-> (!stall_o && (next_pc_o == fetch_pc_o + STEP)));

endmodule

// File: tb/brr_top_tb_top.sv
`timescale 1ns/1ps
module brr_top_tb_top;

   localparam int CLK_HALF = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        s_valid;
   logic [1:0]  s_op;
   logic [31:0] s_pc;
   logic [4:0]  s_ridx;
   logic [31:0] s_rval;
   logic [15:0] s_imm;
   logic [25:0] s_jf;
   logic        s_exw;
   logic [4:0]  s_exrd;

   logic [31:0] fpc0, npc0, fpc1, npc1;
   logic        kil0, stl0, kil1, stl1;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   logic [31:0] pc_m [2];
   logic        kill_m [2];
   logic [31:0] pc_nx [2];
   logic        kill_nx [2];

   always #(CLK_HALF) clk = ~clk;

   brr_top #(.DELAY_SLOT(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n), .id_valid(s_valid), .id_op(s_op), .id_pc(s_pc),
      .id_rs_idx(s_ridx), .id_rs_val(s_rval), .id_imm(s_imm), .id_jfield(s_jf),
      .ex_wr_en(s_exw), .ex_rd(s_exrd), .fetch_pc_o(fpc0), .next_pc_o(npc0),
      .id_kill_o(kil0), .stall_o(stl0)
   );

   brr_top #(.DELAY_SLOT(1'b1)) dut_ds_i (
      .clk(clk), .rst_n(rst_n), .id_valid(s_valid), .id_op(s_op), .id_pc(s_pc),
      .id_rs_idx(s_ridx), .id_rs_val(s_rval), .id_imm(s_imm), .id_jfield(s_jf),
      .ex_wr_en(s_exw), .ex_rd(s_exrd), .fetch_pc_o(fpc1), .next_pc_o(npc1),
      .id_kill_o(kil1), .stall_o(stl1)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] exp_target(input logic [1:0] op, input logic [31:0] pc,
                                              input logic [15:0] imm, input logic [25:0] jf);
      if (op == 2'd3) return {pc[31:28], jf, 2'b00};
      return pc + {{16{imm[15]}}, imm};
   endfunction

   task automatic check_unit(input int u, input logic [31:0] fpc, input logic [31:0] npc,
                             input logic kl, input logic st);
      bit eff, is_cond, take, stall_e, redir;
      logic [31:0] nxt;
      string tag;
      eff     = s_valid && !kill_m[u];
      is_cond = eff && (s_op == 2'd1 || s_op == 2'd2);
      take    = eff && ((s_op == 2'd1 && s_rval == 0) || (s_op == 2'd2 && s_rval != 0) ||
                        s_op == 2'd3);
      stall_e = is_cond && s_exw && (s_exrd == s_ridx) && (s_ridx != 0);
      redir   = take && !stall_e;
      nxt     = stall_e ? pc_m[u] : (redir ? exp_target(s_op, s_pc, s_imm, s_jf) : pc_m[u] + 4);
      if (kill_m[u] && s_valid && s_op != 2'd0) tag = "R8";
      else if (stall_e) tag = "R9";
      else if (eff && s_op == 2'd3) tag = "R4";
      else if (is_cond) tag = "R3";
      else tag = "R2";
      chk(fpc == pc_m[u], "R5", "fetch_pc", fpc, pc_m[u]);
      chk(npc == nxt, tag, "next_pc", npc, nxt);
      if (is_cond && s_ridx == 0 && s_exw && s_exrd == 0)
         chk(st == stall_e, "R10", "stall", 32'(st), 32'(stall_e));
      else
         chk(st == stall_e, kill_m[u] ? "R8" : "R9", "stall", 32'(st), 32'(stall_e));
      chk(kl == kill_m[u], (u == 0) ? "R7" : "R6", "kill", 32'(kl), 32'(kill_m[u]));
      pc_nx[u]   = nxt;
      kill_nx[u] = (u == 0) ? redir : 1'b0;
   endtask

   task automatic run_cycle();
      #5;
      check_unit(0, fpc0, npc0, kil0, stl0);
      check_unit(1, fpc1, npc1, kil1, stl1);
      @(posedge clk);
      for (int u = 0; u < 2; u++) begin
         pc_m[u]   = pc_nx[u];
         kill_m[u] = kill_nx[u];
      end
      @(negedge clk);
   endtask

   task automatic drive(input logic v, input logic [1:0] op, input logic [31:0] pc,
                        input logic [4:0] ridx, input logic [31:0] rval, input logic [15:0] imm,
                        input logic [25:0] jf, input logic exw, input logic [4:0] exrd);
      s_valid = v; s_op = op; s_pc = pc; s_ridx = ridx; s_rval = rval;
      s_imm = imm; s_jf = jf; s_exw = exw; s_exrd = exrd;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R5 watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int unsigned seed_sink;
      seed_sink = $urandom(32'd24680);
      drive(0, 2'd0, 32'h0, 5'd0, 32'h0, 16'h0, 26'h0, 1'b0, 5'd0);
      for (int u = 0; u < 2; u++) begin
         pc_m[u] = 32'h0;
         kill_m[u] = 1'b0;
      end
      repeat (3) begin
         @(negedge clk);
         #5;
         chk(fpc0 == 32'h0 && fpc1 == 32'h0, "R1", "reset pc", fpc0 | fpc1, 32'h0);
         chk(!kil0 && !kil1, "R1", "reset kill", 32'(kil0 | kil1), 32'h0);
         chk(!stl0 && !stl1, "R1", "reset stall", 32'(stl0 | stl1), 32'h0);
      end
      @(negedge clk);
      rst_n = 1'b1;

      // R2: idle decode, sequential fetch
      drive(0, 2'd0, 32'h0, 5'd0, 32'h0, 16'h0, 26'h0, 1'b0, 5'd0);
      run_cycle();
      run_cycle();
      // R3: taken branch-if-zero with negative displacement
      drive(1, 2'd1, 32'h100, 5'd1, 32'h0, 16'hFFF0, 26'h0, 1'b0, 5'd0);
      run_cycle();
      // R8: successor is a taken branch; squash build ignores it
      drive(1, 2'd2, 32'h104, 5'd1, 32'h5, 16'h0040, 26'h0, 1'b0, 5'd0);
      run_cycle();
      // R9: producer in execute on source register
      drive(1, 2'd2, 32'h200, 5'd2, 32'h1, 16'h0010, 26'h0, 1'b1, 5'd2);
      run_cycle();
      drive(1, 2'd2, 32'h200, 5'd2, 32'h1, 16'h0010, 26'h0, 1'b0, 5'd2);
      run_cycle();
      // R10: index zero never stalls
      drive(0, 2'd0, 32'h0, 5'd0, 32'h0, 16'h0, 26'h0, 1'b0, 5'd0);
      run_cycle();
      drive(1, 2'd1, 32'h300, 5'd0, 32'h0, 16'h0008, 26'h0, 1'b1, 5'd0);
      run_cycle();
      // R4: jump behind a writer does not stall
      drive(1, 2'd3, 32'hA000_0010, 5'd3, 32'h9, 16'h0, 26'h0123, 1'b1, 5'd3);
      run_cycle();
      drive(0, 2'd0, 32'h0, 5'd0, 32'h0, 16'h0, 26'h0, 1'b0, 5'd0);
      run_cycle();
      // R3: not-taken branch-if-zero
      drive(1, 2'd1, 32'h400, 5'd4, 32'h7, 16'h0020, 26'h0, 1'b0, 5'd0);
      run_cycle();

      for (int i = 0; i < 4000; i++) begin
         drive(($urandom % 100) < 85, 2'($urandom), $urandom, 5'($urandom % 4),
               (($urandom % 2) == 0) ? 32'h0 : $urandom, 16'($urandom), 26'($urandom),
               1'($urandom), 5'($urandom % 4));
         run_cycle();
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule